// File: doc/BRIEF.md
# Ramp Discontinuity Locator for Pipelined Converter Stages

This block watches the digital output of a pipelined converter while a slow, monotonic ramp is applied to its input and the coarse low bit of one stage is held at zero. Under that condition the output code jumps wherever the selected stage crosses one of its decision edges. The block finds those jumps inside a programmable code window and keeps the earliest and the latest of them. It reports the signed distance of each from an ideal code supplied by the test program. It also flags the stage when either distance exceeds a tolerance that halves for every later stage.

A second mode estimates the converter offset. With the input grounded, the block adds up a power-of-two number of output samples, divides with a shift, and subtracts the mid-scale code. Each run is armed by a one-cycle start command. It ends by itself after a programmed number of valid samples in locate mode, or after the fixed sample count in offset mode. All results are then held with a done flag until the next start.

Top module: `tcd_transition_finder`

## Requirements
- R1: A start pulse clears done and every result output to zero and raises busy in the next cycle. mode_i=0 selects locate mode and mode_i=1 selects offset mode. A sample presented in the same cycle as start is not used.
- R2: In locate mode, two consecutive valid samples form a jump when their absolute difference is strictly greater than jump_thr_i. The reported transition code is the earlier sample of the pair.
- R3: A jump is counted only when its earlier sample lies in [win_lo_i, win_hi_i], both bounds inclusive.
- R4: first_code_o holds the earliest counted jump and last_code_o the latest. found_o is 1 when at least one jump was counted. With a single jump, both codes are equal.
- R5: A locate run takes scan_len_i valid samples. The clock edge that takes the last of them sets done and clears busy. A value of 0 behaves as 1. done and busy are never high together.
- R6: first_off_o equals first_code_o minus ideal_first_i, and last_off_o equals last_code_o minus ideal_last_i. Both are two's complement with CODE_W+1 bits.
- R7: The tolerance is base_tol_i shifted right by stage_i. range_err_o is 1 when a jump was found and the magnitude of either offset is strictly greater than the tolerance. A magnitude equal to the tolerance is not an error.
- R8: When no jump was found, found_o, range_err_o, both codes and both offsets are 0 at done.
- R9: Offset mode takes 2^AVG_LOG2 valid samples. adc_off_o is then floor(sum / 2^AVG_LOG2) - 2^(CODE_W-1), in two's complement with CODE_W+1 bits.
- R10: Cycles with code_valid_i low are ignored. They neither count toward the run length nor break the pairing of consecutive valid samples.
- R11: After reset, busy_o, done_o, found_o, range_err_o and all codes and offsets are 0.
- R12: After done, all results stay constant and further samples are ignored until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command that arms a new run |
| mode_i | input | 1 | 0 locate jumps, 1 estimate offset (taken at start) |
| stage_i | input | STG_W | Stage index; the tolerance shifts right by this amount |
| win_lo_i | input | CODE_W | Lowest code a counted jump may start from |
| win_hi_i | input | CODE_W | Highest code a counted jump may start from |
| jump_thr_i | input | CODE_W | A step must exceed this to be a jump |
| scan_len_i | input | LEN_W | Valid samples per locate run |
| ideal_first_i | input | CODE_W | Ideal position of the first transition code |
| ideal_last_i | input | CODE_W | Ideal position of the last transition code |
| base_tol_i | input | CODE_W | Tolerance for stage 0 |
| code_valid_i | input | 1 | code_i carries a sample this cycle |
| code_i | input | CODE_W | Converter output code |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Results valid and held |
| found_o | output | 1 | At least one jump counted |
| first_code_o | output | CODE_W | Earliest counted transition code |
| last_code_o | output | CODE_W | Latest counted transition code |
| first_off_o | output | CODE_W+1 | Signed offset of the first code from ideal |
| last_off_o | output | CODE_W+1 | Signed offset of the last code from ideal |
| range_err_o | output | 1 | An offset exceeds the stage tolerance |
| adc_off_o | output | CODE_W+1 | Signed converter offset from offset mode |

## Verification
Locate mode is driven with synthetic ramps that dip by a fixed depth over part of the scan. This gives one downward and one upward step with different sizes. Varying the threshold around both step sizes shows the strict comparison and the choice of the earlier sample. Moving the window's lower bound shows that first and last codes are picked independently. Shifting the ideal codes to exactly the tolerance, and one stage later past it, separates the equal case from the excess case and checks the halving. A shortened scan confirms the run length. Runs with idle gaps between samples must give the same results as dense runs. Offset mode is fed constant and alternating levels on both sides of mid-scale, which exposes the sign and the floor of the shift.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_AVG  = 2'd2
    } tcd_state_e;
endpackage

// File: rtl/tcd_jump_detect.sv
module tcd_jump_detect #(
    parameter int CODE_W = 10
) (
    input  logic              prev_ok_i,
    input  logic [CODE_W-1:0] prev_i,
    input  logic [CODE_W-1:0] cur_i,
    input  logic [CODE_W-1:0] thr_i,
    input  logic [CODE_W-1:0] lo_i,
    input  logic [CODE_W-1:0] hi_i,
    output logic              hit_o
);
    localparam int DW = CODE_W + 1;

    logic [DW-1:0] step;
    logic [DW-1:0] step_mag;
    logic          in_win;

    always_comb begin
        step     = {1'b0, cur_i} - {1'b0, prev_i};
        step_mag = step[DW-1] ? (~step + 1'b1) : step;
        in_win   = (prev_i >= lo_i) && (prev_i <= hi_i);
        hit_o    = prev_ok_i && in_win && (step_mag > {1'b0, thr_i});
    end
endmodule

// File: rtl/tcd_offset_eval.sv
module tcd_offset_eval #(
    parameter int CODE_W = 10,
    parameter int STG_W  = 3
) (
    input  logic                   found_i,
    input  logic [1:0][CODE_W-1:0] meas_i,
    input  logic [1:0][CODE_W-1:0] ideal_i,
    input  logic [CODE_W-1:0]      base_tol_i,
    input  logic [STG_W-1:0]       stage_i,
    output logic [1:0][CODE_W:0]   off_o,
    output logic                   err_o
);
    localparam int DW = CODE_W + 1;

    logic [CODE_W-1:0] tol;
    logic [1:0]        over;

    assign tol = base_tol_i >> stage_i;

    for (genvar g = 0; g < 2; g++) begin : g_edge
        logic [DW-1:0] diff;
        logic [DW-1:0] mag;
        always_comb begin
            diff     = {1'b0, meas_i[g]} - {1'b0, ideal_i[g]};
            mag      = diff[DW-1] ? (~diff + 1'b1) : diff;
            over[g]  = mag > {1'b0, tol};
            off_o[g] = found_i ? diff : '0;
        end
    end

    assign err_o = found_i && (|over);
endmodule

// File: rtl/tcd_mean_offset.sv
module tcd_mean_offset #(
    parameter int CODE_W   = 10,
    parameter int AVG_LOG2 = 4
) (
    input  logic [CODE_W+AVG_LOG2-1:0] acc_i,
    output logic [CODE_W:0]            off_o
);
    localparam int                ACC_W = CODE_W + AVG_LOG2;
    localparam logic [CODE_W:0]   MID   = (CODE_W+1)'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] mean;

    assign mean  = acc_i[ACC_W-1:AVG_LOG2];
    assign off_o = {1'b0, mean} - MID;
endmodule

// File: rtl/tcd_transition_finder.sv
module tcd_transition_finder
    import tcd_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int STAGES   = 8,
    parameter int AVG_LOG2 = 4,
    parameter int LEN_W    = 16,
    localparam int STG_W   = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     mode_i,
    input  logic [STG_W-1:0]         stage_i,
    input  logic [CODE_W-1:0]        win_lo_i,
    input  logic [CODE_W-1:0]        win_hi_i,
    input  logic [CODE_W-1:0]        jump_thr_i,
    input  logic [LEN_W-1:0]         scan_len_i,
    input  logic [CODE_W-1:0]        ideal_first_i,
    input  logic [CODE_W-1:0]        ideal_last_i,
    input  logic [CODE_W-1:0]        base_tol_i,
    input  logic                     code_valid_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     found_o,
    output logic [CODE_W-1:0]        first_code_o,
    output logic [CODE_W-1:0]        last_code_o,
    output logic signed [CODE_W:0]   first_off_o,
    output logic signed [CODE_W:0]   last_off_o,
    output logic                     range_err_o,
    output logic signed [CODE_W:0]   adc_off_o
);
    localparam int              ACC_W   = CODE_W + AVG_LOG2;
    localparam int              OFF_W   = CODE_W + 1;
    localparam logic [LEN_W-1:0] AVG_LAST = LEN_W'((1 << AVG_LOG2) - 1);

    typedef struct packed {
        tcd_state_e        st;
        logic              done;
        logic              have_prev;
        logic [CODE_W-1:0] prev;
        logic [LEN_W-1:0]  cnt;
        logic              found;
        logic [CODE_W-1:0] first;
        logic [CODE_W-1:0] last;
        logic [OFF_W-1:0]  off_f;
        logic [OFF_W-1:0]  off_l;
        logic              err;
        logic [ACC_W-1:0]  acc;
        logic [OFF_W-1:0]  adc_off;
    } regs_t;

    regs_t r_q, r_d;

    logic                   hit;
    logic                   found_n;
    logic [CODE_W-1:0]      first_n;
    logic [CODE_W-1:0]      last_n;
    logic [1:0][OFF_W-1:0]  off_n;
    logic                   err_n;
    logic [ACC_W-1:0]       acc_n;
    logic [OFF_W-1:0]       mean_off;
    logic                   scan_last;
    logic                   avg_last;

    tcd_jump_detect #(.CODE_W(CODE_W)) u_jump (
        .prev_ok_i (r_q.have_prev),
        .prev_i    (r_q.prev),
        .cur_i     (code_i),
        .thr_i     (jump_thr_i),
        .lo_i      (win_lo_i),
        .hi_i      (win_hi_i),
        .hit_o     (hit)
    );

    always_comb begin
        found_n = r_q.found;
        first_n = r_q.first;
        last_n  = r_q.last;
        if (hit) begin
            found_n = 1'b1;
            first_n = r_q.found ? r_q.first : r_q.prev;
            last_n  = r_q.prev;
        end
    end

    tcd_offset_eval #(.CODE_W(CODE_W), .STG_W(STG_W)) u_eval (
        .found_i    (found_n),
        .meas_i     ({last_n, first_n}),
        .ideal_i    ({ideal_last_i, ideal_first_i}),
        .base_tol_i (base_tol_i),
        .stage_i    (stage_i),
        .off_o      (off_n),
        .err_o      (err_n)
    );

    assign acc_n = r_q.acc + ACC_W'(code_i);

    tcd_mean_offset #(.CODE_W(CODE_W), .AVG_LOG2(AVG_LOG2)) u_mean (
        .acc_i (acc_n),
        .off_o (mean_off)
    );

    assign scan_last = ({1'b0, r_q.cnt} + 1'b1) >= {1'b0, scan_len_i};
    assign avg_last  = (r_q.cnt == AVG_LAST);

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d    = '0;
            r_d.st = mode_i ? ST_AVG : ST_SCAN;
        end else begin
            case (r_q.st)
                ST_SCAN: begin
                    if (code_valid_i) begin
                        r_d.have_prev = 1'b1;
                        r_d.prev      = code_i;
                        r_d.cnt       = r_q.cnt + 1'b1;
                        r_d.found     = found_n;
                        r_d.first     = first_n;
                        r_d.last      = last_n;
                        if (scan_last) begin
                            r_d.st    = ST_IDLE;
                            r_d.done  = 1'b1;
                            r_d.off_f = off_n[0];
                            r_d.off_l = off_n[1];
                            r_d.err   = err_n;
                        end
                    end
                end
                ST_AVG: begin
                    if (code_valid_i) begin
                        r_d.acc = acc_n;
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (avg_last) begin
                            r_d.st      = ST_IDLE;
                            r_d.done    = 1'b1;
                            r_d.adc_off = mean_off;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign found_o      = r_q.found && r_q.done;
    assign first_code_o = r_q.done ? r_q.first : '0;
    assign last_code_o  = r_q.done ? r_q.last : '0;
    assign first_off_o  = $signed(r_q.off_f);
    assign last_off_o   = $signed(r_q.off_l);
    assign range_err_o  = r_q.err;
    assign adc_off_o    = $signed(r_q.adc_off);
endmodule

// File: rtl/tcd_transition_finder_chk.sv
module tcd_transition_finder_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              found_o,
    input logic              range_err_o,
    input logic [CODE_W-1:0] first_code_o,
    input logic [CODE_W-1:0] last_code_o,
    input logic [CODE_W:0]   first_off_o,
    input logic [CODE_W:0]   adc_off_o
);
    AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o)); // R5

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o)); // R1

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(first_code_o) && $stable(last_code_o)
                                  && $stable(adc_off_o) && $stable(range_err_o))); // R12

    AST_ERR_NEEDS_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |-> found_o); // R7

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (first_code_o == '0 && last_code_o == '0
                                  && first_off_o == '0)); // R8

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o); // R12
endmodule

bind tcd_transition_finder tcd_transition_finder_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .found_o      (found_o),
    .range_err_o  (range_err_o),
    .first_code_o (first_code_o),
    .last_code_o  (last_code_o),
    .first_off_o  (first_off_o),
    .adc_off_o    (adc_off_o)
);

// File: tb/tcd_transition_finder_test.sv
module tcd_transition_finder_test;
    localparam int W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              mode_i = 1'b0;
    logic [2:0]        stage_i = '0;
    logic [W-1:0]      win_lo_i = '0;
    logic [W-1:0]      win_hi_i = '1;
    logic [W-1:0]      jump_thr_i = '0;
    logic [15:0]       scan_len_i = '0;
    logic [W-1:0]      ideal_first_i = '0;
    logic [W-1:0]      ideal_last_i = '0;
    logic [W-1:0]      base_tol_i = '0;
    logic              code_valid_i = 1'b0;
    logic [W-1:0]      code_i = '0;
    logic              busy_o, done_o, found_o, range_err_o;
    logic [W-1:0]      first_code_o, last_code_o;
    logic signed [W:0] first_off_o, last_off_o, adc_off_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    tcd_transition_finder uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .stage_i(stage_i),
        .win_lo_i(win_lo_i), .win_hi_i(win_hi_i), .jump_thr_i(jump_thr_i),
        .scan_len_i(scan_len_i), .ideal_first_i(ideal_first_i), .ideal_last_i(ideal_last_i),
        .base_tol_i(base_tol_i), .code_valid_i(code_valid_i), .code_i(code_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .first_code_o(first_code_o),
        .last_code_o(last_code_o), .first_off_o(first_off_o), .last_off_o(last_off_o),
        .range_err_o(range_err_o), .adc_off_o(adc_off_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ramp with a dip: base + k, lowered by drop while k is in [j1, j1+dur)
    typedef struct packed {
        int base; int n; int j1; int dur; int drop; int thr; int lo; int hi;
        int idf; int idl; int tol; int stg; int gap;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{100, 60, 20, 15, 8, 3,   0, 1023, 119, 126, 8, 0, 0}, // R2 R4: both steps
        '{100, 60, 20, 15, 8, 3, 120, 1023, 119, 126, 8, 0, 0}, // R3: first out of window
        '{100, 60, 20, 15, 8, 3,   0, 1023, 111, 126, 8, 0, 0}, // R7: offset equal to tol
        '{100, 60, 20, 15, 8, 3,   0, 1023, 111, 126, 8, 1, 0}, // R7: tol halved
        '{100, 60, 20, 15, 8, 7,   0, 1023, 119, 126, 8, 0, 0}, // R2: step 7 not > 7
        '{100, 60, 20, 15, 8, 9,   0, 1023, 119, 126, 8, 0, 0}, // R8: no jump
        '{100, 60, 20, 15, 8, 3,   0, 1023, 119, 126, 8, 0, 1}, // R10: idle gaps
        '{100, 60, 20, 15, 8, 3,   0, 1023, 125, 130, 8, 2, 0}, // R6 R7: negative offsets
        '{100, 25, 20, 15, 8, 3,   0, 1023, 119, 126, 8, 0, 0}  // R5: short scan
    };

    function automatic int ramp(input vec_t v, input int k);
        return v.base + k - ((k >= v.j1 && k < v.j1 + v.dur) ? v.drop : 0);
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int e_found = 0, e_first = 0, e_last = 0, e_of = 0, e_ol = 0, e_err = 0, tol;
        for (int k = 1; k < v.n; k++) begin
            int a = ramp(v, k - 1);
            int b = ramp(v, k);
            int d = (b > a) ? b - a : a - b;
            if (d > v.thr && a >= v.lo && a <= v.hi) begin
                if (!e_found) e_first = a;
                e_last = a;
                e_found = 1;
            end
        end
        tol = v.tol >> v.stg;
        if (e_found) begin
            e_of = e_first - v.idf;
            e_ol = e_last - v.idl;
            e_err = ((e_of > tol) || (-e_of > tol) || (e_ol > tol) || (-e_ol > tol)) ? 1 : 0;
        end
        @(negedge clk);
        mode_i = 1'b0; stage_i = 3'(v.stg); win_lo_i = W'(v.lo); win_hi_i = W'(v.hi);
        jump_thr_i = W'(v.thr); scan_len_i = 16'(v.n); ideal_first_i = W'(v.idf);
        ideal_last_i = W'(v.idl); base_tol_i = W'(v.tol); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < v.n; k++) begin
            code_valid_i = 1'b1; code_i = W'(ramp(v, k));
            @(negedge clk);
            if (v.gap != 0) begin
                code_valid_i = 1'b0; code_i = W'(900);
                @(negedge clk);
            end
        end
        code_valid_i = 1'b0;
        $display("vector %0d", idx);
        check("R5 done", int'(done_o), 1);
        check("R5 busy", int'(busy_o), 0);
        check("R4 found", int'(found_o), e_found);
        check("R4 first_code", int'(first_code_o), e_first);
        check("R4 last_code", int'(last_code_o), e_last);
        check("R6 first_off", int'(first_off_o), e_of);
        check("R6 last_off", int'(last_off_o), e_ol);
        check("R7 range_err", int'(range_err_o), e_err);
    endtask

    task automatic run_avg(input int lv_a, input int lv_b, input int exp_off);
        @(negedge clk);
        mode_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 busy after start", int'(busy_o), 1);
        check("R1 done cleared", int'(done_o), 0);
        for (int k = 0; k < 16; k++) begin
            code_valid_i = 1'b1; code_i = W'((k % 2 == 0) ? lv_a : lv_b);
            @(negedge clk);
        end
        code_valid_i = 1'b0;
        check("R9 done", int'(done_o), 1);
        check("R9 adc_off", int'(adc_off_o), exp_off);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 busy", int'(busy_o), 0);
        check("R11 done", int'(done_o), 0);
        check("R11 found", int'(found_o), 0);
        check("R11 first_code", int'(first_code_o), 0);
        check("R11 adc_off", int'(adc_off_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after release", int'(busy_o), 0);

        foreach (VECS[i]) run_vec(VECS[i], i);

        // R12: large steps after done leave results untouched
        run_vec(VECS[0], 100);
        for (int k = 0; k < 6; k++) begin
            code_valid_i = 1'b1; code_i = W'((k % 2 == 0) ? 10 : 700);
            @(negedge clk);
        end
        code_valid_i = 1'b0;
        check("R12 done held", int'(done_o), 1);
        check("R12 first held", int'(first_code_o), 119);
        check("R12 last held", int'(last_code_o), 126);

        // R1: start clears held results
        @(negedge clk);
        mode_i = 1'b0; scan_len_i = 16'd50; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 done cleared", int'(done_o), 0);
        check("R1 first cleared", int'(first_code_o), 0);
        check("R1 busy", int'(busy_o), 1);

        // R9: offset mode, floor of the mean
        run_avg(500, 500, -12);
        run_avg(510, 511, -2);
        run_avg(520, 520, 8);
        run_avg(512, 513, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule